// File: doc/BRIEF.md
# Raster-Operation Block Transfer Engine

This block copies a rectangle of 8-bit pixels from one region of video memory to another. For every destination pixel it combines a source byte with the byte already in place through a selectable binary raster operation. A transparency compare can suppress the write for chosen result colours. The source may be a monochrome bitmap that is expanded into foreground and background colours. It may also be an 8×8 tile that repeats across the rectangle. Both traversal directions are supported, so overlapping copies can be ordered safely.

Software programs the geometry, the addresses and the operation through a byte-wide register port, then sets the start bit. The engine then walks the rectangle on its own through a byte-wide memory port. It has one access in flight at a time, and the memory answers each request with a ready pulse. When the rectangle is done the start and busy bits drop back to zero.

Top module: `rop_blitter`

## Requirements
- R1: The width and height registers are inclusive. A run touches width+1 pixels on each of height+1 rows, so exactly (width+1)×(height+1) destination writes happen when no write is suppressed.
- R2: Raster codes give the result from source S and destination D as follows: 0x0D S; 0x06 D; 0x00 all zeros; 0x0E all ones; 0x05 S&D; 0x6D S|D; 0x59 S^D; 0x0B ~D; 0xD0 ~S; 0x09 S&~D; 0x50 ~S&D; 0xAD S|~D; 0xD6 ~S|D; 0x90 ~(S|D); 0x95 ~(S^D); 0xDA ~(S&D).
- R3: Any raster code outside that table yields D, so the destination byte keeps its value.
- R4: When mode bit 3 is set, the write of a pixel is skipped if (result AND NOT mask) equals (colour AND NOT mask), using the 8-bit transparency colour and mask registers.
- R5: When mode bit 7 is set, each source byte supplies 8 pixels. The most significant bit goes first. A 1 selects the foreground register and a 0 the background register. The source address moves by one byte after every 8 pixels of a row.
- R6: When mode bit 6 is set, the source is an 8×8 tile at the source base. Pixel x of row y reads tile row y mod 8. Full-colour tiles take base+8×(y mod 8)+(x mod 8). Expanded tiles (bit 7 also set) take base+(y mod 8), bit 7−(x mod 8).
- R7: Outside tile mode, pixel x of row y uses destination base+dpitch×y+x. The source is base+spitch×y+x, or base+spitch×y+x/8 when expanded.
- R8: When mode bit 0 is set, every offset in R6 and R7 is subtracted from the base instead of added.
- R9: Writing a 1 to bit 1 of the control register (offset 20) starts a run. While the run is active, reading offset 20 returns 0x03 (bit 1 start, bit 0 busy). After the last pixel it returns 0x00.
- R10: While a run is active, writes to any register, including a second start, are ignored. The run finishes with the settings it started with.
- R11: A memory request stays asserted, with a stable address and direction, until the cycle in which ready is high. No request is raised while idle.
- R12: After reset the engine is idle, raises no request, and every register reads zero.
- R13: Register offsets, one byte each, low byte first: width 0–1, height 2–3, destination pitch 4–5, source pitch 6–7, destination address 8–10, source address 11–13, mode 14, raster code 15, transparency colour 16, transparency mask 17, foreground 18, background 19, control/status 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register offset for write and readback |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Readback of the addressed register or status |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write when high |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access completes in this cycle |

## Verification
A wrong pointer or counter inside the engine shows up as a misplaced or missing byte in memory after the run. A wrong pitch or tile reset becomes visible at the second row or the ninth pixel, so every case uses at least two rows and, where tiles or expansion are involved, more than eight pixels per row. Comparing the whole memory image against a model computed straight from the address formulas catches both corrupted bytes and stray writes outside the rectangle. Write counts and the status readback expose an early or late end of the run within the same operation.

// File: rtl/blit_pkg.sv
// Package: shared constants, state type and raster-code helpers for the
// block-transfer engine. Assumes 8-bit pixels and 16-bit dimensions.
package blit_pkg;
    localparam int DIM_W   = 16;
    localparam int NCFG    = 20;  // stored configuration bytes
    localparam int RA_W    = 5;
    localparam int RG_WID  = 0;
    localparam int RG_HGT  = 2;
    localparam int RG_DPI  = 4;
    localparam int RG_SPI  = 6;
    localparam int RG_DST  = 8;
    localparam int RG_SRC  = 11;
    localparam int RG_MODE = 14;
    localparam int RG_ROP  = 15;
    localparam int RG_TCOL = 16;
    localparam int RG_TMSK = 17;
    localparam int RG_FG   = 18;
    localparam int RG_BG   = 19;
    localparam int RG_CTRL = 20;

    localparam int MB_BACK  = 0;
    localparam int MB_TRANS = 3;
    localparam int MB_PAT   = 6;
    localparam int MB_EXP   = 7;

    typedef enum logic [2:0] {ST_IDLE, ST_SRC, ST_DST, ST_WR, ST_ADV} blit_st_e;

    // Combine source and destination under a raster code; unknown codes keep D.
    function automatic logic [7:0] rop_apply(input logic [7:0] code,
                                             input logic [7:0] s,
                                             input logic [7:0] d);
        case (code)
            8'h00:   rop_apply = 8'h00;
            8'h05:   rop_apply = s & d;
            8'h06:   rop_apply = d;
            8'h09:   rop_apply = s & ~d;
            8'h0B:   rop_apply = ~d;
            8'h0D:   rop_apply = s;
            8'h0E:   rop_apply = 8'hFF;
            8'h50:   rop_apply = ~s & d;
            8'h59:   rop_apply = s ^ d;
            8'h6D:   rop_apply = s | d;
            8'h90:   rop_apply = ~(s | d);
            8'h95:   rop_apply = ~(s ^ d);
            8'hAD:   rop_apply = s | ~d;
            8'hD0:   rop_apply = ~s;
            8'hD6:   rop_apply = ~s | d;
            8'hDA:   rop_apply = ~(s & d);
            default: rop_apply = d;
        endcase
    endfunction

    // True when the raster code depends on the source byte.
    function automatic logic rop_needs_src(input logic [7:0] code);
        case (code)
            8'h05, 8'h09, 8'h0D, 8'h50, 8'h59, 8'h6D,
            8'h90, 8'h95, 8'hAD, 8'hD0, 8'hD6, 8'hDA: rop_needs_src = 1'b1;
            default:                                  rop_needs_src = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/blit_regs.sv
// Register file: holds the configuration bytes and decodes the start bit.
// Assumes the sequencer reports busy; every write is dropped while busy.
module blit_regs
    import blit_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [RA_W-1:0]          cfg_addr,
    input  logic [7:0]               cfg_wdata,
    input  logic                     busy,
    output logic [7:0]               cfg_rdata,
    output logic                     start,
    output logic [NCFG-1:0][7:0]     regs_q
);
    // Accept configuration writes only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (cfg_we && !busy && (cfg_addr < RA_W'(NCFG))) begin
            regs_q[cfg_addr] <= cfg_wdata;
        end
    end

    // Start pulse from a control write with bit 1 set, idle only.
    assign start = cfg_we && !busy && (cfg_addr == RA_W'(RG_CTRL)) && cfg_wdata[1];

    // Readback of configuration bytes or the status byte.
    always_comb begin
        if (cfg_addr == RA_W'(RG_CTRL))
            cfg_rdata = {6'b0, busy, busy};
        else if (cfg_addr < RA_W'(NCFG))
            cfg_rdata = regs_q[cfg_addr];
        else
            cfg_rdata = 8'h00;
    end

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> $stable(regs_q));
endmodule

// File: rtl/blit_pix.sv
// Pixel datapath: forms the effective source (optionally colour-expanded),
// applies the raster code and evaluates the transparency compare.
// Purely combinational; inputs are held stable by the sequencer.
module blit_pix
    import blit_pkg::*;
(
    input  logic [7:0] mode,
    input  logic [7:0] rop,
    input  logic [7:0] src_q,
    input  logic [7:0] dst_q,
    input  logic [7:0] fg,
    input  logic [7:0] bg,
    input  logic [2:0] bit_sel,
    input  logic [7:0] tcol,
    input  logic [7:0] tmask,
    output logic [7:0] result,
    output logic       skip_wr
);
    logic [7:0] s_eff;

    // Choose expanded colour or raw source, then combine and compare.
    always_comb begin
        s_eff   = mode[MB_EXP] ? (src_q[3'd7 - bit_sel] ? fg : bg) : src_q;
        result  = rop_apply(rop, s_eff, dst_q);
        skip_wr = mode[MB_TRANS] && ((result & ~tmask) == (tcol & ~tmask));
    end
endmodule

// File: rtl/blit_seq.sv
// Sequencer: walks the rectangle pixel by pixel, keeps row and pixel
// pointers for both directions, tiles and expansion, and runs the
// single-outstanding memory handshake. Configuration is static while busy.
module blit_seq
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    input  logic [DIM_W-1:0]  dpitch,
    input  logic [DIM_W-1:0]  spitch,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [7:0]        mode,
    input  logic              need_src,
    input  logic              skip_wr,
    input  logic              mem_ready,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        src_q,
    output logic [7:0]        dst_q,
    output logic [2:0]        bit_sel
);
    localparam int PAD = ADDR_W - DIM_W;

    blit_st_e          state;
    logic [DIM_W-1:0]  cx, cy, y_nx;
    logic [ADDR_W-1:0] d_ptr, s_ptr, row_d, row_s, row_d_nx, row_s_nx;
    logic              back, pat, expd, last_x, last;

    // Add or subtract an offset depending on traversal direction.
    function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                               input logic [ADDR_W-1:0] n,
                                               input logic              rev);
        step = rev ? a - n : a + n;
    endfunction

    // Tile row offset: one byte per row when expanded, eight otherwise.
    function automatic logic [ADDR_W-1:0] tile_ofs(input logic [2:0] r, input logic ex);
        tile_ofs = ex ? ADDR_W'({3'b000, r}) : ADDR_W'({r, 3'b000});
    endfunction

    // Decode mode and position flags for the next-pointer logic.
    always_comb begin
        back     = mode[MB_BACK];
        pat      = mode[MB_PAT];
        expd     = mode[MB_EXP];
        last_x   = (cx == width);
        last     = last_x && (cy == height);
        y_nx     = cy + 1'b1;
        row_d_nx = step(row_d, {{PAD{1'b0}}, dpitch}, back);
        row_s_nx = step(row_s, {{PAD{1'b0}}, spitch}, back);
    end

    // Main state machine and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cx    <= '0;
            cy    <= '0;
            d_ptr <= '0;
            s_ptr <= '0;
            row_d <= '0;
            row_s <= '0;
            src_q <= '0;
            dst_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cx    <= '0;
                    cy    <= '0;
                    d_ptr <= dst_base;
                    row_d <= dst_base;
                    s_ptr <= src_base;
                    row_s <= src_base;
                    state <= need_src ? ST_SRC : ST_DST;
                end
                ST_SRC: if (mem_ready) begin
                    src_q <= mem_rdata;
                    state <= ST_DST;
                end
                ST_DST: if (mem_ready) begin
                    dst_q <= mem_rdata;
                    state <= ST_WR;
                end
                ST_WR: if (skip_wr || mem_ready) state <= ST_ADV;
                ST_ADV: begin
                    if (last) begin
                        state <= ST_IDLE;
                    end else begin
                        state <= need_src ? ST_SRC : ST_DST;
                        if (last_x) begin
                            cx    <= '0;
                            cy    <= y_nx;
                            row_d <= row_d_nx;
                            d_ptr <= row_d_nx;
                            row_s <= row_s_nx;
                            s_ptr <= pat ? step(src_base, tile_ofs(y_nx[2:0], expd), back)
                                         : row_s_nx;
                        end else begin
                            cx    <= cx + 1'b1;
                            d_ptr <= step(d_ptr, ADDR_W'(1), back);
                            if (pat) begin
                                if (cx[2:0] == 3'd7)
                                    s_ptr <= step(src_base, tile_ofs(cy[2:0], expd), back);
                                else if (!expd)
                                    s_ptr <= step(s_ptr, ADDR_W'(1), back);
                            end else if (!expd || cx[2:0] == 3'd7) begin
                                s_ptr <= step(s_ptr, ADDR_W'(1), back);
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory request decode from the current state.
    always_comb begin
        busy     = (state != ST_IDLE);
        mem_req  = (state == ST_SRC) || (state == ST_DST) || ((state == ST_WR) && !skip_wr);
        mem_we   = (state == ST_WR);
        mem_addr = (state == ST_SRC) ? s_ptr : d_ptr;
        bit_sel  = cx[2:0];
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R1
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cx <= width));
    // R1
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cy <= height));
endmodule

// File: rtl/rop_blitter.sv
// Top: raster-operation block transfer engine. Joins the register file,
// the sequencer and the pixel datapath. ADDR_W must lie in 17..24.
module rop_blitter
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready
);
    logic [NCFG-1:0][7:0] regs_q;
    logic                 start, busy, skip_wr;
    logic [7:0]           src_q, dst_q;
    logic [2:0]           bit_sel;
    logic [23:0]          dst_full, src_full;

    // Assemble multi-byte address fields.
    always_comb begin
        dst_full = {regs_q[RG_DST+2], regs_q[RG_DST+1], regs_q[RG_DST]};
        src_full = {regs_q[RG_SRC+2], regs_q[RG_SRC+1], regs_q[RG_SRC]};
    end

    blit_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .cfg_rdata (cfg_rdata),
        .start     (start),
        .regs_q    (regs_q)
    );

    blit_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .width     ({regs_q[RG_WID+1], regs_q[RG_WID]}),
        .height    ({regs_q[RG_HGT+1], regs_q[RG_HGT]}),
        .dpitch    ({regs_q[RG_DPI+1], regs_q[RG_DPI]}),
        .spitch    ({regs_q[RG_SPI+1], regs_q[RG_SPI]}),
        .dst_base  (dst_full[ADDR_W-1:0]),
        .src_base  (src_full[ADDR_W-1:0]),
        .mode      (regs_q[RG_MODE]),
        .need_src  (rop_needs_src(regs_q[RG_ROP])),
        .skip_wr   (skip_wr),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .bit_sel   (bit_sel)
    );

    blit_pix u_pix (
        .mode    (regs_q[RG_MODE]),
        .rop     (regs_q[RG_ROP]),
        .src_q   (src_q),
        .dst_q   (dst_q),
        .fg      (regs_q[RG_FG]),
        .bg      (regs_q[RG_BG]),
        .bit_sel (bit_sel),
        .tcol    (regs_q[RG_TCOL]),
        .tmask   (regs_q[RG_TMSK]),
        .result  (mem_wdata),
        .skip_wr (skip_wr)
    );

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cfg_we && cfg_addr == 5'd20));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !mem_req);
endmodule

// File: tb/sim_rop_blitter.sv
// Bench: memory model with varying latency, a direct-formula reference
// and whole-image compares over sweeps of sizes, codes and modes.
module sim_rop_blitter;
    localparam int PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          ready = 1'b0;

    logic [7:0] mem  [4096];
    logic [7:0] refm [4096];
    int checks = 0, errors = 0, wr_cnt = 0, hs_bad = 0, wcnt = 0, nxtlat = 1;
    bit done_flag = 0, p_req = 0, p_rdy = 0;

    int g_w, g_h, g_dp, g_sp, g_dst, g_src, g_mode, g_rop, g_tc, g_tm, g_fg, g_bg;

    always #(PERIOD/2) clk = ~clk;

    rop_blitter #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(ready)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    // Memory responder with latency cycling 0..2 and handshake monitor.
    always @(posedge clk) begin
        if (ready) begin
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            ready  <= 1'b0;
            wcnt   <= nxtlat;
            nxtlat <= (nxtlat == 2) ? 0 : nxtlat + 1;
        end else if (mem_req) begin
            if (wcnt == 0) ready <= 1'b1;
            else wcnt <= wcnt - 1;
        end
        if (rst_n && p_req && !p_rdy && !mem_req) hs_bad <= hs_bad + 1;
        p_req <= rst_n && mem_req;
        p_rdy <= ready;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_mem(input int seed);
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = 8'((i * 73 + seed * 29 + (i >> 5)) ^ (i >> 3));
            refm[i] = mem[i];
        end
    endtask

    task automatic program_regs();
        cfg_write(0, g_w & 255);   cfg_write(1, g_w >> 8);
        cfg_write(2, g_h & 255);   cfg_write(3, g_h >> 8);
        cfg_write(4, g_dp & 255);  cfg_write(5, g_dp >> 8);
        cfg_write(6, g_sp & 255);  cfg_write(7, g_sp >> 8);
        cfg_write(8, g_dst & 255); cfg_write(9, (g_dst >> 8) & 255); cfg_write(10, 0);
        cfg_write(11, g_src & 255); cfg_write(12, (g_src >> 8) & 255); cfg_write(13, 0);
        cfg_write(14, g_mode); cfg_write(15, g_rop);
        cfg_write(16, g_tc); cfg_write(17, g_tm);
        cfg_write(18, g_fg); cfg_write(19, g_bg);
    endtask

    task automatic wait_done();
        cfg_addr = 5'd20;
        @(negedge clk);
        while (cfg_rdata[0]) @(negedge clk);
    endtask

    function automatic logic [7:0] ref_rop(input int c, input logic [7:0] s, input logic [7:0] d);
        case (c)
            8'h00: return 8'h00;   8'h05: return s & d;     8'h06: return d;
            8'h09: return s & ~d;  8'h0B: return ~d;        8'h0D: return s;
            8'h0E: return 8'hFF;   8'h50: return ~s & d;    8'h59: return s ^ d;
            8'h6D: return s | d;   8'h90: return ~(s | d);  8'h95: return ~(s ^ d);
            8'hAD: return s | ~d;  8'hD0: return ~s;        8'hD6: return ~s | d;
            8'hDA: return ~(s & d);
            default: return d;
        endcase
    endfunction

    // Reference: every address computed from its closed-form expression.
    task automatic ref_run();
        int sgn = (g_mode & 1) ? -1 : 1;
        bit ex = (g_mode >> 7) & 1, pt = (g_mode >> 6) & 1, tr = (g_mode >> 3) & 1;
        for (int y = 0; y <= g_h; y++) begin
            for (int x = 0; x <= g_w; x++) begin
                int da, sa;
                logic [7:0] s, d, r, tm;
                da = (g_dst + sgn * (g_dp * y + x)) & 'hFFF;
                if (pt) sa = (g_src + sgn * (ex ? (y % 8) : (8 * (y % 8) + x % 8))) & 'hFFF;
                else    sa = (g_src + sgn * (g_sp * y + (ex ? x / 8 : x))) & 'hFFF;
                s = refm[sa];
                if (ex) s = s[7 - (x % 8)] ? 8'(g_fg) : 8'(g_bg);
                d = refm[da];
                r = ref_rop(g_rop, s, d);
                tm = ~8'(g_tm);
                if (!(tr && ((r & tm) == (8'(g_tc) & tm)))) refm[da] = r;
            end
        end
    endtask

    task automatic compare(input string req);
        int bad = -1;
        for (int i = 0; i < 4096; i++)
            if (bad < 0 && mem[i] !== refm[i]) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, {bad, 8'(mem[bad])}, {bad, 8'(refm[bad])});
    endtask

    task automatic run_case(input string req, input int seed);
        load_mem(seed);
        program_regs();
        wr_cnt = 0;
        cfg_write(20, 8'h02);
        wait_done();
        ref_run();
        compare(req);
    endtask

    task automatic defaults();
        g_w = 6; g_h = 3; g_dp = 32; g_sp = 24; g_dst = 'h800; g_src = 'h100;
        g_mode = 0; g_rop = 'h0D; g_tc = 0; g_tm = 0; g_fg = 'hC3; g_bg = 'h3C;
    endtask

    // Watchdog: a hang counts as a failed check and still reports.
    initial begin
        #(PERIOD * 150000);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [16] = '{8'h00, 8'h05, 8'h06, 8'h09, 8'h0B, 8'h0D, 8'h0E, 8'h50,
                                   8'h59, 8'h6D, 8'h90, 8'h95, 8'hAD, 8'hD0, 8'hD6, 8'hDA};
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(mem_req === 1'b0, "R12 req", mem_req, 0);
        cfg_addr = 5'd20; #1;
        chk(cfg_rdata === 8'h00, "R12 status", cfg_rdata, 0);
        cfg_addr = 5'd0; #1;
        chk(cfg_rdata === 8'h00, "R12 reg", cfg_rdata, 0);
        rst_n = 1'b1;

        // R2: every listed raster code
        for (int k = 0; k < 16; k++) begin
            defaults(); g_rop = codes[k];
            run_case($sformatf("R2 rop %0h", codes[k]), k);
        end
        // R3: unlisted codes keep the destination
        foreach (codes[k]) if (k < 3) begin
            defaults(); g_rop = (k == 0) ? 'h01 : (k == 1) ? 'h7F : 'hFF;
            run_case("R3 unlisted", 40 + k);
        end
        // R1: inclusive sizes and write count; R13 byte layout via programming
        for (int w = 0; w < 4; w++) begin
            for (int h = 0; h < 3; h++) begin
                defaults(); g_w = w; g_h = h;
                run_case("R1 size", w * 3 + h);
                chk(wr_cnt == (w + 1) * (h + 1), "R1 count", wr_cnt, (w + 1) * (h + 1));
            end
        end
        // R13: a width above 255 needs the high byte
        defaults(); g_w = 300; g_h = 1; g_dp = 512; g_sp = 512; g_dst = 'h600; g_src = 'h000;
        run_case("R13 wide", 7);
        // R7: pitch variants, including zero and overlap
        defaults(); g_dp = 100; g_sp = 7; run_case("R7 pitch", 3);
        defaults(); g_dp = 0; g_rop = 'h59; run_case("R7 zero pitch", 4);
        defaults(); g_src = 'h800; g_dst = 'h801; g_dp = 16; g_sp = 16; run_case("R7 overlap", 5);
        // R4: transparency with partial, full and zero mask
        defaults(); g_mode = 8; g_tc = 'h5A; g_tm = 'h0F; g_w = 30; g_h = 5; run_case("R4 partial", 9);
        defaults(); g_mode = 8; g_tc = 'h11; g_tm = 'hFF; run_case("R4 all masked", 10);
        chk(wr_cnt == 0, "R4 no writes", wr_cnt, 0);
        defaults(); g_mode = 8; g_rop = 'h0E; g_tc = 'hFF; g_tm = 'h00; run_case("R4 exact", 11);
        // R5: colour expansion
        defaults(); g_mode = 'h80; g_w = 19; g_h = 2; run_case("R5 expand", 12);
        defaults(); g_mode = 'h88; g_w = 23; g_h = 3; g_rop = 'h59; g_tc = 'hC3 ^ 'h11; g_tm = 0;
        run_case("R5 expand xor", 13);
        // R6: tiles, full colour and expanded, beyond 8 rows and columns
        defaults(); g_mode = 'h40; g_w = 20; g_h = 10; run_case("R6 tile", 14);
        defaults(); g_mode = 'hC0; g_w = 17; g_h = 9; run_case("R6 tile expand", 15);
        defaults(); g_mode = 'h40; g_w = 9; g_h = 8; g_rop = 'h95; run_case("R6 tile rop", 16);
        // R8: reverse traversal in each source form
        defaults(); g_mode = 1; g_dst = 'hBFF; g_src = 'h4FF; run_case("R8 back", 17);
        defaults(); g_mode = 'h81; g_dst = 'hBFF; g_src = 'h4FF; g_w = 17; run_case("R8 back expand", 18);
        defaults(); g_mode = 'h41; g_dst = 'hBFF; g_src = 'h4FF; g_w = 12; g_h = 9; run_case("R8 back tile", 19);

        // R9 and R10: status while running, writes ignored while busy
        defaults(); g_w = 7;
        load_mem(21); program_regs(); wr_cnt = 0;
        cfg_write(20, 8'h02);
        cfg_addr = 5'd20; #1;
        chk(cfg_rdata === 8'h03, "R9 status busy", cfg_rdata, 3);
        cfg_write(0, 1); cfg_write(15, 0); cfg_write(20, 8'h02);
        wait_done(); #1;
        chk(cfg_rdata === 8'h00, "R9 status done", cfg_rdata, 0);
        cfg_addr = 5'd0; #1;
        chk(cfg_rdata === 8'h07, "R10 width kept", cfg_rdata, 7);
        cfg_addr = 5'd15; #1;
        chk(cfg_rdata === 8'h0D, "R10 rop kept", cfg_rdata, 'h0D);
        ref_run(); compare("R10 run intact");
        repeat (4) @(negedge clk);
        chk(wr_cnt == 32, "R10 no second run", wr_cnt, 32);
        // R11: request never withdrawn before ready
        chk(hs_bad == 0, "R11 handshake", hs_bad, 0);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule